// File: doc/BRIEF.md
# Raster Sync and Region Timing Generator

This block produces the complete timing skeleton of a fixed raster. It runs on the pixel-rate clock and keeps two counters: a horizontal position within the current scanline and a line number within the current frame. From these counters it decodes active-low horizontal and vertical sync, a window flag for the region where pixel fetch and pixel output may happen, a frame interrupt flag that covers the bottom border, and single-cycle strobes that mark the first cycle of every line and of every frame.

Colour logic, memory address generation and interrupt handling sit downstream and consume these flags. The vertical sync pulse releases halfway through its last line instead of at a line boundary. That gives the half-line offset of an interlace-style composite sync. All outputs are decoded from the registered counters, so they are free of glitches relative to the clock. Every output changes in the same cycle as the counter value it reflects.

Top module: `raster_timing`

## Requirements
- R1: `h_pos` counts up by one on every clock and returns to 0 after 1023, giving 1024 cycles per scanline.
- R2: `v_line` holds its value except in the cycle where `h_pos` goes from 1023 to 0. In that cycle it advances by one. After line 311 it returns to 0, giving 312 lines per frame.
- R3: `hsync_n` is 0 while `h_pos` is below 75 and 1 for `h_pos` from 75 to 1023, on every line.
- R4: `vsync_n` is 0 from line 0 position 0 up to and including line 2 position 511. It is 1 from line 2 position 512 through the end of line 311.
- R5: The vertical window covers lines 38 to 293 inclusive, which is 256 lines.
- R6: The horizontal window covers positions 256 to 895 inclusive, which is 640 positions. `active` is 1 exactly when both the vertical and the horizontal window hold.
- R7: `frame_irq` is 1 on lines 294 to 311 and 0 on lines 0 to 293. It therefore rises at line 294 position 0 and falls at line 0 position 0.
- R8: `line_start` is 1 exactly in the cycle where `h_pos` is 0. `frame_start` is 1 exactly when `h_pos` is 0 and `v_line` is 0.
- R9: `rst` is synchronous. While it is sampled high, `h_pos` and `v_line` are 0, both sync outputs are 0, and `line_start` and `frame_start` are 1. The first clock edge with `rst` low moves `h_pos` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | Inside the fetch and pixel window |
| frame_irq | output | 1 | Bottom-of-picture interrupt flag |
| line_start | output | 1 | First cycle of a scanline |
| frame_start | output | 1 | First cycle of a frame |
| h_pos | output | 10 | Position within the scanline |
| v_line | output | 9 | Line within the frame |

## Verification
The default-sized block runs freely from one reset for more than 38 lines. This exposes the sync edges, the half-line vsync release and the start of the vertical window at their real positions. A second copy with a scaled-down raster runs several complete frames and is reset at random moments. This separates errors in frame wrap, in the rise and fall of the interrupt flag and in reset restart from errors in the decode boundaries. Every cycle, all outputs of both copies are compared against an expected position, which is derived from the number of clock edges since reset.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Half-open interval test: lo <= v < hi
  function automatic logic in_span(input int v, input int lo, input int hi);
    return (v >= lo) && (v < hi);
  endfunction

  // Vertical sync asserted until (end_line, end_pos) is reached
  function automatic logic vs_asserted(input int line, input int pos,
                                       input int end_line, input int end_pos);
    return (line < end_line) || ((line == end_line) && (pos < end_pos));
  endfunction

  // Width of a counter that counts 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int LINE_LEN = 1024,
  parameter int PW       = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] pos,
  output logic          wrap
);
  logic [PW-1:0] pos_q;

  assign wrap = (int'(pos_q) == LINE_LEN - 1);
  assign pos  = pos_q;

  always_ff @(posedge clk) begin
    if (rst)       pos_q <= '0;
    else if (wrap) pos_q <= '0;
    else           pos_q <= pos_q + PW'(1);
  end

  // R1: the counter returns to zero after the last position
  p_pos_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (pos == '0));
  // R1: the counter steps by one elsewhere
  p_pos_step_r1: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (pos == $past(pos) + PW'(1)));
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
  parameter int FRAME_LINES = 312,
  parameter int LW          = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  output logic [LW-1:0] line,
  output logic          last_line
);
  logic [LW-1:0] line_q;

  assign last_line = (int'(line_q) == FRAME_LINES - 1);
  assign line      = line_q;

  always_ff @(posedge clk) begin
    if (rst)                      line_q <= '0;
    else if (advance && last_line) line_q <= '0;
    else if (advance)             line_q <= line_q + LW'(1);
  end

  // R2: the line holds between position wraps
  p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(line));
  // R2: the frame restarts after the last line
  p_line_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (advance && last_line) |=> (line == '0));
endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int PW          = 10,
  parameter int LW          = 9,
  parameter int HS_END      = 75,
  parameter int VS_END_LINE = 2,
  parameter int VS_END_POS  = 512,
  parameter int ACT_V_START = 38,
  parameter int ACT_V_LINES = 256,
  parameter int ACT_H_START = 256,
  parameter int ACT_H_LEN   = 640
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pos,
  input  logic [LW-1:0] line,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          h_win,
  output logic          v_win,
  output logic          irq,
  output logic          sol,
  output logic          sof
);
  localparam int ACT_V_END = ACT_V_START + ACT_V_LINES;
  localparam int ACT_H_END = ACT_H_START + ACT_H_LEN;

  int p_i, l_i;
  assign p_i = int'(pos);
  assign l_i = int'(line);

  always_comb begin
    hsync_n = !in_span(p_i, 0, HS_END);
    vsync_n = !vs_asserted(l_i, p_i, VS_END_LINE, VS_END_POS);
    h_win   = in_span(p_i, ACT_H_START, ACT_H_END);
    v_win   = in_span(l_i, ACT_V_START, ACT_V_END);
    irq     = (l_i >= ACT_V_END);
    sol     = (p_i == 0);
    sof     = sol && (l_i == 0);
  end

  // R3: hsync releases only at its end position
  p_hs_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_n) |-> (p_i == HS_END));
  // R4: vsync releases mid-line on its end line
  p_vs_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync_n) |-> (l_i == VS_END_LINE && p_i == VS_END_POS));
  // R7: interrupt rises at the first cycle below the picture
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (l_i == ACT_V_END && p_i == 0));
endmodule

// File: rtl/raster_timing.sv
module raster_timing
  import raster_pkg::*;
#(
  parameter int LINE_LEN    = 1024,
  parameter int FRAME_LINES = 312,
  parameter int HS_END      = 75,
  parameter int VS_END_LINE = 2,
  parameter int VS_END_POS  = 512,
  parameter int ACT_V_START = 38,
  parameter int ACT_V_LINES = 256,
  parameter int ACT_H_START = 256,
  parameter int ACT_H_LEN   = 640,
  localparam int PW = cnt_width(LINE_LEN),
  localparam int LW = cnt_width(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          active,
  output logic          frame_irq,
  output logic          line_start,
  output logic          frame_start,
  output logic [PW-1:0] h_pos,
  output logic [LW-1:0] v_line
);
  logic pos_wrap, last_line, h_win, v_win;

  raster_hcount #(.LINE_LEN(LINE_LEN), .PW(PW)) u_hcount (
    .clk(clk), .rst(rst), .pos(h_pos), .wrap(pos_wrap));

  raster_vcount #(.FRAME_LINES(FRAME_LINES), .LW(LW)) u_vcount (
    .clk(clk), .rst(rst), .advance(pos_wrap), .line(v_line),
    .last_line(last_line));

  raster_decode #(
    .PW(PW), .LW(LW), .HS_END(HS_END), .VS_END_LINE(VS_END_LINE),
    .VS_END_POS(VS_END_POS), .ACT_V_START(ACT_V_START),
    .ACT_V_LINES(ACT_V_LINES), .ACT_H_START(ACT_H_START),
    .ACT_H_LEN(ACT_H_LEN)
  ) u_decode (
    .clk(clk), .rst(rst), .pos(h_pos), .line(v_line),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .h_win(h_win), .v_win(v_win),
    .irq(frame_irq), .sol(line_start), .sof(frame_start));

  assign active = h_win && v_win;

  // R8: a frame strobe is always also a line strobe
  p_frame_in_line_r8: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start);
  // R6/R7: the window never overlaps the interrupt region
  p_active_no_irq_r6: assert property (@(posedge clk) disable iff (rst)
    active |-> !frame_irq);
  // R2: the last line is only left through a position wrap
  p_last_exit_r2: assert property (@(posedge clk) disable iff (rst)
    (last_line && !pos_wrap) |=> (int'(v_line) == FRAME_LINES - 1));
endmodule

// File: tb/raster_timing_bench.sv
module raster_timing_bench;
  // Scaled raster for the second copy
  localparam int SL = 32, SF = 20, SHS = 5, SVL = 2, SVP = 16;
  localparam int SVA = 4, SVN = 12, SHA = 8, SHN = 20;

  logic clk = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  always #5 clk = ~clk;

  logic hs_a, vs_a, act_a, irq_a, ls_a, fs_a;
  logic [9:0] hp_a;
  logic [8:0] vl_a;
  logic hs_b, vs_b, act_b, irq_b, ls_b, fs_b;
  logic [4:0] hp_b;
  logic [4:0] vl_b;

  raster_timing u_raster_timing (
    .clk(clk), .rst(rst_a), .hsync_n(hs_a), .vsync_n(vs_a), .active(act_a),
    .frame_irq(irq_a), .line_start(ls_a), .frame_start(fs_a),
    .h_pos(hp_a), .v_line(vl_a));

  raster_timing #(
    .LINE_LEN(SL), .FRAME_LINES(SF), .HS_END(SHS), .VS_END_LINE(SVL),
    .VS_END_POS(SVP), .ACT_V_START(SVA), .ACT_V_LINES(SVN),
    .ACT_H_START(SHA), .ACT_H_LEN(SHN)
  ) u_raster_small (
    .clk(clk), .rst(rst_b), .hsync_n(hs_b), .vsync_n(vs_b), .active(act_b),
    .frame_irq(irq_b), .line_start(ls_b), .frame_start(fs_b),
    .h_pos(hp_b), .v_line(vl_b));

  int vectors = 0, fails = 0;
  int ka = 0, kb = 0;
  bit done = 0;

  // Edges since reset, counted independently of the design
  always @(posedge clk) begin
    ka <= rst_a ? 0 : ka + 1;
    kb <= rst_b ? 0 : kb + 1;
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Expected outputs from an edge count and raster dimensions
  task automatic check_copy(input int k, input int L, input int F, input int hse,
      input int vel, input int vep, input int vas, input int van, input int has,
      input int han, input int hs, input int vs, input int act, input int irq,
      input int ls, input int fs, input int hp, input int vl);
    int p, l;
    p = k % L;
    l = (k / L) % F;
    chk("R1", "h_pos", hp, p);
    chk("R2", "v_line", vl, l);
    chk("R3", "hsync_n", hs, (p >= hse) ? 1 : 0);
    chk("R4", "vsync_n", vs, ((l > vel) || (l == vel && p >= vep)) ? 1 : 0);
    chk("R5_R6", "active", act,
        (l >= vas && l < vas + van && p >= has && p < has + han) ? 1 : 0);
    chk("R7", "frame_irq", irq, (l >= vas + van) ? 1 : 0);
    chk("R8", "line_start", ls, (p == 0) ? 1 : 0);
    chk("R8", "frame_start", fs, (p == 0 && l == 0) ? 1 : 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done && $time > 20) begin
      check_copy(ka, 1024, 312, 75, 2, 512, 38, 256, 256, 640,
                 int'(hs_a), int'(vs_a), int'(act_a), int'(irq_a),
                 int'(ls_a), int'(fs_a), int'(hp_a), int'(vl_a));
      check_copy(kb, SL, SF, SHS, SVL, SVP, SVA, SVN, SHA, SHN,
                 int'(hs_b), int'(vs_b), int'(act_b), int'(irq_b),
                 int'(ls_b), int'(fs_b), int'(hp_b), int'(vl_b));
    end
  end

  initial begin
    int seed;
    int rv;
    seed = 32'h5eed;
    rv = $urandom(seed);
    repeat (3) @(negedge clk);
    // R9: reset state, both syncs low and strobes high
    chk("R9", "hsync_n in reset", int'(hs_a), 0);
    chk("R9", "vsync_n in reset", int'(vs_a), 0);
    chk("R9", "frame_start in reset", int'(fs_a), 1);
    rst_a = 1'b0;
    rst_b = 1'b0;
    @(negedge clk);
    chk("R9", "h_pos after release", int'(hp_a), 1);
    // Directed: three full small frames without reset
    repeat (3 * SL * SF) @(negedge clk);
    // Random resets on the small copy while the large copy runs on
    for (int i = 0; i < 60; i++) begin
      repeat ($urandom_range(700, 50)) @(negedge clk);
      rst_b = 1'b1;
      repeat ($urandom_range(3, 1)) @(negedge clk);
      rst_b = 1'b0;
    end
    // Large copy past the start of its vertical window (R5)
    while (ka < 39 * 1024 + 1000) @(negedge clk);
    // Random mid-line reset on the large copy (R9)
    repeat ($urandom_range(900, 10)) @(negedge clk);
    rst_a = 1'b1;
    @(negedge clk);
    rst_a = 1'b0;
    repeat (3000) @(negedge clk);
    finish_run();
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule